// File: doc/BRIEF.md
# Incremental Running Average Engine

This block averages a stream of unsigned samples online. It does not sum the whole set and divide once at the end. After each sample it folds the new value into the running mean with the update `avg_new = (avg * i + s(i)) / (i + 1)`, where `i` is the count of samples already absorbed. The quotient is truncated. The number of samples `N` is fixed by a parameter.

A small controller steps a datapath. The datapath holds:
- an average register with its own load enable;
- an index register with its own load enable;
- a comparator that tests the index against `N`;
- a processing element that forms the product-sum and divides it with a bit-serial restoring divider.

The index register drives the address of an external sample store. A read strobe marks the cycle in which the sample must be valid on `sample_i`, and the store must return the sample in that same cycle. When all `N` samples are absorbed, the controller enters its fifth state, the output state. There it drives the average out, raises the output valid and raises done. Both flags stay high until the next start.

Top module: `avg_stream_engine`

## Requirements
- R1: A start pulse accepted in the idle or output state clears the average and index registers to zero. No value from an earlier run influences the next result.
- R2: Each step computes `(avg*i + s(i)) / (i+1)` with the quotient truncated toward zero. It then loads the quotient into the average register and increments the index by one.
- R3: A run issues exactly `N` reads, and no read happens once the index has reached `N`.
- R4: Each read strobe carries the current index as the address. The addresses of a run are 0, 1, …, N-1 in ascending order.
- R5: `avg_o` is zero whenever `avg_vld_o` is low. `avg_vld_o` is high only in the output state.
- R6: `done_o` and `avg_vld_o` are high together. Once set, both stay high with a stable `avg_o` until a new start pulse.
- R7: A start pulse that arrives while samples are still being fetched or divided has no effect. The run completes with the same reads and the same result.
- R8: Full-scale 16-bit samples (65535) produce no overflow. The product-sum is held at 32 bits, and the result equals 65535.
- R9: The engine gives results equal to the truncating reference for N = 2, 5 and 9.
- R10: After reset, `done_o`, `avg_vld_o` and `rd_o` are low and `avg_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new averaging run |
| rd_o | output | 1 | Sample read strobe |
| addr_o | output | ADDR_W | Sample address (current index) |
| sample_i | input | SAMPLE_W | Sample data, valid while `rd_o` is high |
| avg_o | output | SAMPLE_W | Average, nonzero only while valid |
| avg_vld_o | output | 1 | Average output enable |
| done_o | output | 1 | All N samples absorbed |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a run, while the divider is busy. In that state a wrong design would silently restart and re-read address zero. The stimulus pulses `start_i` a few cycles after a run begins, in the middle of the first division. It then checks three things: the read count still equals `N`, the addresses stay in order, and the final value matches the reference. Clearing is exposed by running a small-valued set right after a full-scale set, so any leftover average or index would change the result.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_FETCH = 3'd2,
    ST_CALC  = 3'd3,
    ST_SHOW  = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/avg_cmp.sv
module avg_cmp #(
  parameter int ADDR_W    = 4,
  parameter int N_SAMPLES = 5
) (
  input  logic [ADDR_W-1:0] idx_i,
  output logic              lt_o
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(N_SAMPLES);
  assign lt_o = (idx_i < LIMIT);
endmodule

// File: rtl/avg_pe.sv
module avg_pe #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 4,
  parameter int ACC_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] avg_i,
  input  logic [ADDR_W-1:0]   idx_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(ACC_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_W - 1);

  logic [ACC_W-1:0] numer, dvsr;
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W:0]   rem_q;
  logic [ACC_W-1:0] quo_q, dvs_q;
  logic [ACC_W:0]   rem_sh;
  logic [ACC_W+1:0] diff;
  logic             ge;

  assign numer  = ACC_W'(avg_i) * ACC_W'(idx_i) + ACC_W'(sample_i);
  assign dvsr   = ACC_W'(idx_i) + ACC_W'(1);
  assign rem_sh = {rem_q[ACC_W-1:0], quo_q[ACC_W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, dvs_q};
  assign ge     = ~diff[ACC_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= numer;
      dvs_q  <= dvsr;
    end else if (busy_q) begin
      quo_q  <= {quo_q[ACC_W-2:0], ge};
      rem_q  <= ge ? diff[ACC_W:0] : rem_sh;
      cnt_q  <= cnt_q + CNT_W'(1);
      busy_q <= (cnt_q != LAST);
      done_q <= (cnt_q == LAST);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q[SAMPLE_W-1:0];

  // The truncated mean never exceeds the largest sample: upper bits stay clear
  assert_quot_fits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (quo_q[ACC_W-1:SAMPLE_W] == '0));
  // The controller never relaunches a divide that is still running
  assert_no_relaunch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic idx_lt_i,
  input  logic div_done_i,
  output logic clr_o,
  output logic rd_o,
  output logic div_start_o,
  output logic la_o,
  output logic li_o,
  output logic show_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    clr_o       = 1'b0;
    rd_o        = 1'b0;
    div_start_o = 1'b0;
    la_o        = 1'b0;
    li_o        = 1'b0;
    show_o      = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CLEAR;
      ST_CLEAR: begin
        clr_o   = 1'b1;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (idx_lt_i) begin
          rd_o        = 1'b1;
          div_start_o = 1'b1;
          state_d     = ST_CALC;
        end else begin
          state_d = ST_SHOW;
        end
      end
      ST_CALC: begin
        if (div_done_i) begin
          la_o    = 1'b1;
          li_o    = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_SHOW: begin
        show_o = 1'b1;
        if (start_i) state_d = ST_CLEAR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // A start during fetch or divide must not send the sequence back to clear
  assert_busy_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state_q == ST_FETCH || state_q == ST_CALC)) |=> (state_q != ST_CLEAR));
endmodule

// File: rtl/avg_stream_engine.sv
module avg_stream_engine #(
  parameter int SAMPLE_W  = 16,
  parameter int ADDR_W    = 4,
  parameter int ACC_W     = 32,
  parameter int N_SAMPLES = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                rd_o,
  output logic [ADDR_W-1:0]   addr_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] avg_o,
  output logic                avg_vld_o,
  output logic                done_o
);
  localparam logic [ADDR_W-1:0] IDX_MAX = ADDR_W'(N_SAMPLES);

  logic                clr, rd, div_start, la, li, show, idx_lt, div_done;
  logic [SAMPLE_W-1:0] avg_q, quot;
  logic [ADDR_W-1:0]   idx_q;

  avg_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .idx_lt_i   (idx_lt),
    .div_done_i (div_done),
    .clr_o      (clr),
    .rd_o       (rd),
    .div_start_o(div_start),
    .la_o       (la),
    .li_o       (li),
    .show_o     (show)
  );

  avg_cmp #(.ADDR_W(ADDR_W), .N_SAMPLES(N_SAMPLES)) u_cmp (
    .idx_i(idx_q),
    .lt_o (idx_lt)
  );

  avg_pe #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_pe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .avg_i   (avg_q),
    .idx_i   (idx_q),
    .sample_i(sample_i),
    .done_o  (div_done),
    .quot_o  (quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  avg_q <= '0;
    else if (clr) avg_q <= '0;
    else if (la)  avg_q <= quot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (li)  idx_q <= idx_q + ADDR_W'(1);
  end

  assign rd_o      = rd;
  assign addr_o    = idx_q;
  assign avg_o     = show ? avg_q : '0;
  assign avg_vld_o = show;
  assign done_o    = show;

  assert_clear_zeroes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (avg_q == '0 && idx_q == '0));
  assert_index_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_MAX);
  assert_avg_loads_on_divide_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    la |-> div_done);
  assert_result_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (show && !start_i) |=> (show && $stable(avg_q)));
endmodule

// File: tb/sim_avg_stream_engine.sv
module sim_avg_stream_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        start_s [3];
  wire         rd_w    [3];
  wire  [3:0]  addr_w  [3];
  wire  [15:0] smp_w   [3];
  wire  [15:0] avg_w   [3];
  wire         vld_w   [3];
  wire         done_w  [3];
  logic [15:0] mem [3][16];
  logic        clr_mon = 1'b0;
  int          nreads [3];
  int          ord_err [3];
  int          leak_err [3];
  int          pair_err [3];

  function automatic int nof(int k);
    return (k == 0) ? 5 : (k == 1) ? 2 : 9;
  endfunction

  assign smp_w[0] = mem[0][addr_w[0]];
  assign smp_w[1] = mem[1][addr_w[1]];
  assign smp_w[2] = mem[2][addr_w[2]];

  avg_stream_engine #(.N_SAMPLES(5)) u0 (.clk_i(clk), .rst_ni(rst_n), .start_i(start_s[0]),
    .rd_o(rd_w[0]), .addr_o(addr_w[0]), .sample_i(smp_w[0]), .avg_o(avg_w[0]),
    .avg_vld_o(vld_w[0]), .done_o(done_w[0]));
  avg_stream_engine #(.N_SAMPLES(2)) u1 (.clk_i(clk), .rst_ni(rst_n), .start_i(start_s[1]),
    .rd_o(rd_w[1]), .addr_o(addr_w[1]), .sample_i(smp_w[1]), .avg_o(avg_w[1]),
    .avg_vld_o(vld_w[1]), .done_o(done_w[1]));
  avg_stream_engine #(.N_SAMPLES(9)) u2 (.clk_i(clk), .rst_ni(rst_n), .start_i(start_s[2]),
    .rd_o(rd_w[2]), .addr_o(addr_w[2]), .sample_i(smp_w[2]), .avg_o(avg_w[2]),
    .avg_vld_o(vld_w[2]), .done_o(done_w[2]));

  // Port monitors sampled away from the active edge
  always @(negedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (clr_mon) begin
        nreads[k] = 0; ord_err[k] = 0; leak_err[k] = 0; pair_err[k] = 0;
      end else begin
        if (rd_w[k]) begin
          if (int'(addr_w[k]) != nreads[k]) ord_err[k]++;
          nreads[k]++;
        end
        if (!vld_w[k] && avg_w[k] != 16'd0) leak_err[k]++;
        if (vld_w[k] != done_w[k]) pair_err[k]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_avg(int k);
    int a = 0;
    for (int i = 0; i < nof(k); i++) a = (a * i + int'(mem[k][i])) / (i + 1);
    return a;
  endfunction

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1'b1;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  task automatic run(input int k, input bit poke, input string req);
    int exp, held;
    exp = ref_avg(k);
    clear_mon();
    start_s[k] = 1'b1;
    @(negedge clk); start_s[k] = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start_s[k] = 1'b1;                   // R7: arrives mid-divide
      @(negedge clk); start_s[k] = 1'b0;
    end
    while (!done_w[k]) @(negedge clk);
    chk(int'(avg_w[k]) == exp, req, int'(avg_w[k]), exp);
    chk(nreads[k] == nof(k), "R3 read count", nreads[k], nof(k));
    chk(ord_err[k] == 0, "R4 address order", ord_err[k], 0);
    chk(leak_err[k] == 0, "R5 output gated", leak_err[k], 0);
    chk(pair_err[k] == 0, "R6 done with valid", pair_err[k], 0);
    held = 1;
    repeat (20) begin
      @(negedge clk);
      if (!done_w[k] || !vld_w[k] || int'(avg_w[k]) != exp) held = 0;
    end
    chk(held == 1, "R6 held until start", held, 1);
    chk(nreads[k] == nof(k), "R3 no read after N", nreads[k], nof(k));
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      chk(!done_w[k] && !vld_w[k] && !rd_w[k], "R10 flags low", int'(done_w[k]), 0);
      chk(avg_w[k] == 16'd0, "R10 avg zero", int'(avg_w[k]), 0);
    end
  endtask

  task automatic t_n5_basic();
    mem[0][0] = 16'd10; mem[0][1] = 16'd3; mem[0][2] = 16'd7;
    mem[0][3] = 16'd100; mem[0][4] = 16'd1;
    run(0, 1'b0, "R2 truncating update N=5");
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < 5; i++) mem[0][i] = 16'hFFFF;
    run(0, 1'b0, "R8 full scale");
  endtask

  task automatic t_restart();
    for (int i = 0; i < 5; i++) mem[0][i] = 16'(i + 1);
    run(0, 1'b0, "R1 restart clears state");
  endtask

  task automatic t_busy_start();
    mem[0][0] = 16'd500; mem[0][1] = 16'd0; mem[0][2] = 16'd999;
    mem[0][3] = 16'd41; mem[0][4] = 16'd12345;
    run(0, 1'b1, "R7 busy start ignored");
  endtask

  task automatic t_n2();
    mem[1][0] = 16'd9; mem[1][1] = 16'd4;
    run(1, 1'b0, "R9 N=2");
  endtask

  task automatic t_n9();
    for (int i = 0; i < 9; i++) mem[2][i] = 16'((i * 7919 + 13) % 65536);
    mem[2][4] = 16'd0;
    run(2, 1'b0, "R9 N=9");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      start_s[k] = 1'b0;
      for (int i = 0; i < 16; i++) mem[k][i] = 16'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_n5_basic();
    t_full_scale();
    t_restart();
    t_busy_start();
    t_n2();
    t_n9();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule